// File: doc/BRIEF.md
# Word FIFO Pair with Flush and Masked Interrupt

This block sits between a register bus and a packet engine and holds two queues of 32-bit words. Software writes outgoing words into the transmit queue, which the engine drains. The engine pushes incoming words into the receive queue, which software reads out. Each queue reports how full it is, compares that level against a programmable trigger to raise a data-request flag, and can be emptied by a self-clearing flush bit.

Writing a word into a full transmit queue drops the word and raises a sticky overflow flag. Reading from an empty receive queue returns zero and raises a sticky underflow flag. The two level-driven request flags and the two sticky error flags form an interrupt status byte. Each sticky bit is cleared by writing a one to it. A mask register selects which status bits drive the single interrupt output.

Register map, word-addressed on `reg_addr`: 0 control, 1 level status, 2 transmit data (write), 3 receive data (read), 4 interrupt status, 5 interrupt mask. Register reads are combinational in the cycle `reg_rd` is high. A read of address 3 pops the receive queue on that clock edge.

Top module: `fpr_fifo_pair`

## Requirements
- R1: Words written to address 2 leave at `eng_tx_data` in the order written, with `eng_tx_valid` high whenever the transmit queue holds a word. Words pushed on `eng_rx_data` are returned by reads of address 3 in the order pushed.
- R2: A read of address 1 returns the number of free transmit slots in bits 7:4 and the number of filled receive slots in bits 3:0. The depth is 8.
- R3: A write to address 2 while the transmit queue holds 8 words is dropped and sets interrupt status bit 5.
- R4: A read of address 3 while the receive queue is empty returns zero and sets interrupt status bit 4.
- R5: Control bit 0 flushes the receive queue and control bit 1 flushes the transmit queue. A flush bit written as 1 reads back as 1 in the following cycle. On the next edge the queue empties and the bit reads back as 0.
- R6: Control bits 4:2 hold the receive trigger n, and bits 7:5 hold the transmit trigger m. Status bit 0 is high while at least n+1 receive slots are filled. Status bit 1 is high while at least m+1 transmit slots are free. Codes 0 and 7 are both supported.
- R7: Writing address 4 clears each of bits 4 and 5 whose written bit is 1. Written ones on bits 0 and 1 have no effect, because those bits follow their trigger condition.
- R8: `irq` is high exactly when some interrupt status bit and the same bit of the mask register at address 5 are both 1.
- R9: After reset both queues are empty, the triggers and mask are zero, the sticky flags are clear, and `irq` is low.
- R10: An engine pop from an empty transmit queue is ignored. An engine push into a full receive queue is dropped, and `eng_rx_ready` is low while that queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, same cycle |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_data | output | 32 | Head transmit word |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Engine delivers a receive word |
| eng_rx_data | input | 32 | Receive word from engine |
| eng_rx_ready | output | 1 | Receive queue not full |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest situations to reach are the ones where a flush and a queue boundary meet. One is a flush issued while a queue is exactly full. The other is a read of the control bit in the single cycle during which it still shows 1. To reach them, the stimulus first fills each queue to its last slot and pushes one more word to force a drop. It then writes the flush together with a nonzero trigger and reads control back on the very next cycle. A behavioural queue model advanced on every clock predicts the outputs and the request levels around these events.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
   localparam int unsigned REG_ADDR_W = 3;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_CTRL  = 3'd0,
      REG_LEVEL = 3'd1,
      REG_TXD   = 3'd2,
      REG_RXD   = 3'd3,
      REG_ISR   = 3'd4,
      REG_IMR   = 3'd5
   } fpr_reg_e;

   // control register field positions
   localparam int unsigned FLUSH_RX_POS = 0;
   localparam int unsigned FLUSH_TX_POS = 1;
   localparam int unsigned RX_TRIG_POS  = 2;
   localparam int unsigned TX_TRIG_POS  = 5;

   // interrupt status positions
   localparam int unsigned IRQ_RX_REQ = 0;
   localparam int unsigned IRQ_TX_REQ = 1;
   localparam int unsigned IRQ_RX_UNF = 4;
   localparam int unsigned IRQ_TX_OVF = 5;
   localparam int unsigned STAT_W     = 8;

   localparam int unsigned LEVEL_FIELD_W = 4;
endpackage

// File: rtl/fpr_fifo.sv
module fpr_fifo #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] head,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic              full,
   output logic              empty
);
   localparam int unsigned PTR_W = $clog2(DEPTH);
   localparam int unsigned CNT_W = $clog2(DEPTH+1);
   localparam bit          POW2  = (DEPTH == (1 << PTR_W));

   if (DEPTH < 2) begin : g_depth_chk
      $error("fpr_fifo: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              do_push, do_pop;

   assign full    = (count == CNT_W'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign head    = mem[rd_ptr];

   // pointer wrap: free for power-of-two depths, explicit compare otherwise
   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R1
   AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> $stable(count)); // R3
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0)); // R5
endmodule

// File: rtl/fpr_ctrl.sv
module fpr_ctrl import fpr_pkg::*; #(
   parameter int unsigned TRIG_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [7:0]        wbyte,
   output logic              flush_rx,
   output logic              flush_tx,
   output logic [TRIG_W-1:0] rx_trig,
   output logic [TRIG_W-1:0] tx_trig
);
   if (TRIG_W > TX_TRIG_POS - RX_TRIG_POS || TX_TRIG_POS + TRIG_W > 8) begin : g_trig_chk
      $error("fpr_ctrl: trigger fields overlap or exceed the control byte");
   end

   // flush bits stay set for exactly one cycle, during which the queue resets
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_rx <= 1'b0;
         flush_tx <= 1'b0;
         rx_trig  <= '0;
         tx_trig  <= '0;
      end else if (wr_en) begin
         flush_rx <= wbyte[FLUSH_RX_POS];
         flush_tx <= wbyte[FLUSH_TX_POS];
         rx_trig  <= wbyte[RX_TRIG_POS +: TRIG_W];
         tx_trig  <= wbyte[TX_TRIG_POS +: TRIG_W];
      end else begin
         flush_rx <= 1'b0;
         flush_tx <= 1'b0;
      end
   end

   AST_FLUSH_RX_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_rx && !wr_en) |=> !flush_rx); // R5
   AST_FLUSH_TX_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_tx && !wr_en) |=> !flush_tx); // R5
endmodule

// File: rtl/fpr_irq.sv
module fpr_irq #(
   parameter int unsigned     NSRC   = 8,
   parameter logic [NSRC-1:0] STICKY = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] level_in,
   input  logic [NSRC-1:0] event_in,
   input  logic            clr_en,
   input  logic [NSRC-1:0] clr_bits,
   input  logic            mask_we,
   input  logic [NSRC-1:0] mask_in,
   output logic [NSRC-1:0] status,
   output logic [NSRC-1:0] mask,
   output logic            irq
);
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (STICKY[i]) begin : g_sticky
         logic st_q;
         always_ff @(posedge clk) begin
            if (!rst_n)           st_q <= 1'b0;
            else if (event_in[i]) st_q <= 1'b1;
            else if (clr_en && clr_bits[i]) st_q <= 1'b0;
         end
         assign status[i] = st_q;

         AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (status[i] && !(clr_en && clr_bits[i])) |=> status[i]); // R7
         AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_en && clr_bits[i] && !event_in[i]) |=> !status[i]); // R7
      end else begin : g_level
         assign status[i] = level_in[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mask <= '0;
      else if (mask_we) mask <= mask_in;
   end

   assign irq = |(status & mask);

   AST_IRQ_QUIET_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq); // R8
endmodule

// File: rtl/fpr_fifo_pair.sv
module fpr_fifo_pair import fpr_pkg::*; #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned TRIG_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  eng_tx_pop,
   output logic [DATA_W-1:0]     eng_tx_data,
   output logic                  eng_tx_valid,
   input  logic                  eng_rx_push,
   input  logic [DATA_W-1:0]     eng_rx_data,
   output logic                  eng_rx_ready,
   output logic                  irq
);
   localparam int unsigned CNT_W = $clog2(DEPTH+1);
   localparam int unsigned CMP_W = ((CNT_W > TRIG_W) ? CNT_W : TRIG_W) + 1;
   localparam logic [STAT_W-1:0] STICKY_SET =
      STAT_W'((1 << IRQ_RX_UNF) | (1 << IRQ_TX_OVF));

   if (DEPTH > (1 << LEVEL_FIELD_W) - 1) begin : g_level_chk
      $error("fpr_fifo_pair: DEPTH does not fit the level status fields");
   end
   if (DATA_W < STAT_W) begin : g_width_chk
      $error("fpr_fifo_pair: DATA_W must hold a status byte");
   end

   logic wr_ctrl, wr_txd, wr_isr, wr_imr, rd_rxd;
   assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
   assign wr_txd  = reg_wr && (reg_addr == REG_TXD);
   assign wr_isr  = reg_wr && (reg_addr == REG_ISR);
   assign wr_imr  = reg_wr && (reg_addr == REG_IMR);
   assign rd_rxd  = reg_rd && (reg_addr == REG_RXD);

   logic              flush_rx, flush_tx;
   logic [TRIG_W-1:0] rx_trig, tx_trig;

   fpr_ctrl #(.TRIG_W(TRIG_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_ctrl),
      .wbyte    (reg_wdata[7:0]),
      .flush_rx (flush_rx),
      .flush_tx (flush_tx),
      .rx_trig  (rx_trig),
      .tx_trig  (tx_trig)
   );

   logic [CNT_W-1:0]  tx_count, rx_count;
   logic              tx_full, tx_empty, rx_full, rx_empty;
   logic [DATA_W-1:0] rx_head;

   fpr_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_tx),
      .push      (wr_txd),
      .push_data (reg_wdata),
      .pop       (eng_tx_pop),
      .head      (eng_tx_data),
      .count     (tx_count),
      .full      (tx_full),
      .empty     (tx_empty)
   );

   fpr_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_rx),
      .push      (eng_rx_push),
      .push_data (eng_rx_data),
      .pop       (rd_rxd),
      .head      (rx_head),
      .count     (rx_count),
      .full      (rx_full),
      .empty     (rx_empty)
   );

   assign eng_tx_valid = !tx_empty;
   assign eng_rx_ready = !rx_full;

   // trigger comparison: code n requests at n+1 or more slots
   logic [CNT_W-1:0] tx_free;
   logic             rx_req, tx_req;
   assign tx_free = CNT_W'(DEPTH) - tx_count;
   assign rx_req  = CMP_W'(rx_count) > CMP_W'(rx_trig);
   assign tx_req  = CMP_W'(tx_free)  > CMP_W'(tx_trig);

   logic ovf_evt, unf_evt;
   assign ovf_evt = wr_txd && tx_full && !flush_tx;
   assign unf_evt = rd_rxd && rx_empty && !flush_rx;

   logic [STAT_W-1:0] level_src, event_src, isr, imr;
   always_comb begin
      level_src             = '0;
      level_src[IRQ_RX_REQ] = rx_req;
      level_src[IRQ_TX_REQ] = tx_req;
      event_src             = '0;
      event_src[IRQ_RX_UNF] = unf_evt;
      event_src[IRQ_TX_OVF] = ovf_evt;
   end

   fpr_irq #(.NSRC(STAT_W), .STICKY(STICKY_SET)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (level_src),
      .event_in (event_src),
      .clr_en   (wr_isr),
      .clr_bits (reg_wdata[STAT_W-1:0]),
      .mask_we  (wr_imr),
      .mask_in  (reg_wdata[STAT_W-1:0]),
      .status   (isr),
      .mask     (imr),
      .irq      (irq)
   );

   // register read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_CTRL: begin
            reg_rdata[FLUSH_RX_POS]            = flush_rx;
            reg_rdata[FLUSH_TX_POS]            = flush_tx;
            reg_rdata[RX_TRIG_POS +: TRIG_W]   = rx_trig;
            reg_rdata[TX_TRIG_POS +: TRIG_W]   = tx_trig;
         end
         REG_LEVEL: begin
            reg_rdata[LEVEL_FIELD_W +: LEVEL_FIELD_W] = LEVEL_FIELD_W'(tx_free);
            reg_rdata[0 +: LEVEL_FIELD_W]             = LEVEL_FIELD_W'(rx_count);
         end
         REG_RXD:  reg_rdata = rx_empty ? '0 : rx_head;
         REG_ISR:  reg_rdata[STAT_W-1:0] = isr;
         REG_IMR:  reg_rdata[STAT_W-1:0] = imr;
         default:  reg_rdata = '0;
      endcase
   end

   AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> isr[IRQ_TX_OVF]); // R3
   AST_UNF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && (reg_addr == REG_RXD) && rx_empty && !flush_rx) |=> isr[IRQ_RX_UNF]); // R4
   AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_tx |=> eng_tx_valid == 1'b0); // R5
endmodule

// File: tb/tb_fpr_fifo_pair.sv
module tb_fpr_fifo_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        eng_tx_pop = 1'b0;
   logic [31:0] eng_tx_data;
   logic        eng_tx_valid;
   logic        eng_rx_push = 1'b0;
   logic [31:0] eng_rx_data = '0;
   logic        eng_rx_ready;
   logic        irq;

   int nchk = 0, nerr = 0;
   bit done = 0;

   always #2 clk = ~clk;

   fpr_fifo_pair dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_valid(eng_tx_valid),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .eng_rx_ready(eng_rx_ready),
      .irq(irq)
   );

   // behavioural reference model
   logic [31:0] txq[$];
   logic [31:0] rxq[$];
   int   txt = 0, rxt = 0;
   bit   pend_tx = 0, pend_rx = 0, ovf = 0, unf = 0;
   logic [7:0] msk = '0;

   function automatic logic [7:0] exp_isr();
      logic [7:0] s = '0;
      s[0] = (rxq.size() >= rxt + 1);
      s[1] = ((8 - txq.size()) >= txt + 1);
      s[4] = unf;
      s[5] = ovf;
      return s;
   endfunction

   function automatic logic [31:0] exp_read(input logic [2:0] a);
      case (a)
         3'd0: return 32'((txt << 5) | (rxt << 2) | (int'(pend_tx) << 1) | int'(pend_rx));
         3'd1: return 32'(((8 - txq.size()) << 4) | rxq.size());
         3'd3: return (rxq.size() != 0) ? rxq[0] : 32'h0;
         3'd4: return {24'h0, exp_isr()};
         3'd5: return {24'h0, msk};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         txq.delete(); rxq.delete();
         txt = 0; rxt = 0; pend_tx = 0; pend_rx = 0; ovf = 0; unf = 0; msk = '0;
      end else begin
         bit t_full, t_empty, r_full, r_empty, s_ovf, s_unf;
         t_full = (txq.size() == 8); t_empty = (txq.size() == 0);
         r_full = (rxq.size() == 8); r_empty = (rxq.size() == 0);
         s_ovf = 0; s_unf = 0;
         if (pend_tx) txq.delete();
         else begin
            if (eng_tx_pop && !t_empty) void'(txq.pop_front());
            if (reg_wr && reg_addr == 3'd2) begin
               if (t_full) s_ovf = 1; else txq.push_back(reg_wdata);
            end
         end
         if (pend_rx) rxq.delete();
         else begin
            if (reg_rd && reg_addr == 3'd3) begin
               if (r_empty) s_unf = 1; else void'(rxq.pop_front());
            end
            if (eng_rx_push && !r_full) rxq.push_back(eng_rx_data);
         end
         if (reg_wr && reg_addr == 3'd0) begin
            pend_rx = reg_wdata[0]; pend_tx = reg_wdata[1];
            rxt = int'(reg_wdata[4:2]); txt = int'(reg_wdata[7:5]);
         end else begin
            pend_rx = 0; pend_tx = 0;
         end
         if (reg_wr && reg_addr == 3'd4) begin
            if (reg_wdata[4]) unf = 0;
            if (reg_wdata[5]) ovf = 0;
         end
         if (s_ovf) ovf = 1;
         if (s_unf) unf = 1;
         if (reg_wr && reg_addr == 3'd5) msk = reg_wdata[7:0];
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         #1;
         chk("R1 tx_valid", 32'(eng_tx_valid), 32'(txq.size() != 0));
         if (txq.size() != 0) chk("R1 tx_data", eng_tx_data, txq[0]);
         chk("R10 rx_ready", 32'(eng_rx_ready), 32'(rxq.size() < 8));
         chk("R8 irq", 32'(irq), 32'(|(exp_isr() & msk)));
      end
   end

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1 reg_wr = 0;
   endtask

   task automatic reg_read(input logic [2:0] a, input string req);
      @(negedge clk); reg_rd = 1; reg_addr = a;
      #1 chk(req, reg_rdata, exp_read(a));
      @(posedge clk); #1 reg_rd = 0;
   endtask

   task automatic reg_read_val(input logic [2:0] a, input logic [31:0] v, input string req);
      @(negedge clk); reg_rd = 1; reg_addr = a;
      #1 chk(req, reg_rdata, v);
      @(posedge clk); #1 reg_rd = 0;
   endtask

   task automatic eng_pop();
      @(negedge clk); eng_tx_pop = 1;
      @(posedge clk); #1 eng_tx_pop = 0;
   endtask

   task automatic eng_push(input logic [31:0] d);
      @(negedge clk); eng_rx_push = 1; eng_rx_data = d;
      @(posedge clk); #1 eng_rx_push = 0;
   endtask

   initial begin
      #(4 * 200000);
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1;
      // R9 reset state, R2 level encoding
      reg_read_val(3'd1, 32'h80, "R9 R2 level after reset");
      reg_read_val(3'd0, 32'h00, "R9 ctrl after reset");
      reg_read_val(3'd4, 32'h02, "R9 R6 isr after reset");
      reg_read_val(3'd5, 32'h00, "R9 mask after reset");
      chk("R9 irq after reset", 32'(irq), 32'h0);
      // R1 ordering through transmit queue
      reg_write(3'd2, 32'hA0A0_0001);
      reg_write(3'd2, 32'hA0A0_0002);
      reg_write(3'd2, 32'hA0A0_0003);
      reg_read_val(3'd1, 32'h50, "R2 level with 3 tx");
      repeat (3) eng_pop();
      eng_pop(); // R10 pop on empty ignored
      reg_read_val(3'd1, 32'h80, "R10 level after empty pop");
      // R3 overflow
      for (int i = 0; i < 8; i++) reg_write(3'd2, 32'hB000_0000 + 32'(i));
      reg_read_val(3'd1, 32'h00, "R2 tx full level");
      reg_write(3'd2, 32'hDEAD_BEEF);
      reg_read_val(3'd4, 32'h20, "R3 overflow flag");
      reg_read_val(3'd1, 32'h00, "R3 dropped word not stored");
      // R8 masking, R7 write-one-to-clear
      reg_write(3'd5, 32'h20);
      chk("R8 irq on masked ovf", 32'(irq), 32'h1);
      reg_write(3'd4, 32'h23);
      reg_read_val(3'd4, 32'h00, "R7 ovf cleared, level bits unaffected");
      chk("R8 irq after clear", 32'(irq), 32'h0);
      // R5 transmit flush with full queue
      reg_write(3'd0, 32'h02);
      reg_read_val(3'd0, 32'h02, "R5 tx flush bit reads 1");
      reg_read_val(3'd0, 32'h00, "R5 tx flush bit self-clears");
      reg_read_val(3'd1, 32'h80, "R5 tx emptied");
      // R6 receive trigger 3
      reg_write(3'd0, 32'h0C);
      for (int i = 0; i < 5; i++) eng_push(32'hC000_0000 + 32'(i));
      reg_read_val(3'd4, 32'h03, "R6 rx request at 5 filled trig 3");
      reg_write(3'd5, 32'h01);
      reg_read(3'd3, "R1 rx word 0");
      reg_read(3'd3, "R1 rx word 1");
      reg_read_val(3'd4, 32'h02, "R6 rx request drops at 3 filled");
      chk("R8 irq low with rx req clear", 32'(irq), 32'h0);
      // R4 underflow
      repeat (3) reg_read(3'd3, "R1 rx drain");
      reg_read_val(3'd3, 32'h0, "R4 empty read returns zero");
      reg_read_val(3'd4, 32'h12, "R4 underflow flag");
      reg_write(3'd4, 32'h10);
      reg_read_val(3'd4, 32'h02, "R7 underflow cleared");
      // R10 receive full, then R5 receive flush
      for (int i = 0; i < 9; i++) eng_push(32'hE000_0000 + 32'(i));
      reg_read_val(3'd1, 32'h88, "R10 rx full, extra push dropped");
      reg_write(3'd0, 32'h0D);
      reg_read_val(3'd0, 32'h0D, "R5 rx flush bit reads 1");
      reg_read_val(3'd0, 32'h0C, "R5 rx flush bit self-clears");
      reg_read_val(3'd1, 32'h80, "R5 rx emptied");
      // R6 transmit trigger 7
      reg_write(3'd0, 32'hE0);
      reg_read_val(3'd4, 32'h02, "R6 tx request at 8 free trig 7");
      reg_write(3'd2, 32'h1234_5678);
      reg_read_val(3'd4, 32'h00, "R6 tx request drops at 7 free");
      eng_pop();
      reg_read_val(3'd4, 32'h02, "R6 tx request back at 8 free");
      repeat (2) @(posedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule